// File: doc/BRIEF.md
# Chip-Select Gated Registered Command Buffer

This block is a single-clock, one-to-one register stage for a DDR2 address and command bus. It registers 21 command bits and a pair each of chip-select, clock-enable and on-die-termination bits, and re-drives them toward the memory devices one clock later.

The 21 command bits can be gated by the chip selects. When the gate input is high, those bits load only on an edge where at least one of the two active-low chip selects is low. On an edge where both chip selects are high, the bits keep their old value. When the gate input is low, the command bits load on every edge. The chip-select, clock-enable and termination bits always reload on every edge, whatever the gate input says.

An asynchronous active-low reset clears every output at once and takes priority over the gating.

Top module: `cmd_reg_buf`

## Requirements
- R1: On a loading edge, `cmd_q` takes the value `cmd_d` had at that rising clock edge.
- R2: With `gate_en` high and both bits of `cs_n_d` high (2'b11) at an edge, `cmd_q` keeps its previous value.
- R3: With `gate_en` high and at least one bit of `cs_n_d` low (2'b00, 2'b01 or 2'b10) at an edge, `cmd_q` loads `cmd_d`.
- R4: With `gate_en` low, `cmd_q` loads `cmd_d` on every edge for all four chip-select values.
- R5: `cke_q` and `odt_q` load `cke_d` and `odt_d` on every edge, whatever `gate_en` and `cs_n_d` are.
- R6: `cs_n_q` loads `cs_n_d` on every edge.
- R7: While `rst_n` is low, every output is 0, from the moment `rst_n` falls and without waiting for a clock edge. This also applies in the middle of a cycle.
- R8: While `rst_n` is low, clock edges have no effect: the outputs stay 0 whatever the inputs are.
- R9: After `rst_n` rises, the first rising clock edge loads the outputs under the normal rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | 1: the command bits load only when a chip select is low |
| cmd_d | input | 21 | Chip-select-gated command/address bits |
| cs_n_d | input | 2 | Active-low chip selects |
| cke_d | input | 2 | Clock-enable bits, not gated |
| odt_d | input | 2 | Termination bits, not gated |
| cmd_q | output | 21 | Registered command bits |
| cs_n_q | output | 2 | Registered chip selects |
| cke_q | output | 2 | Registered clock-enable bits |
| odt_q | output | 2 | Registered termination bits |

## Verification
Two functions can act on the same edge: a chip-select hold of `cmd_q` and the unconditional reload of the clock-enable, termination and chip-select bits. The bench provokes this by driving both chip selects high with gating on while it changes `cke_d`, `odt_d` and `cmd_d`. It then judges that `cmd_q` is unchanged while the other outputs follow their inputs. The bench also pulls the reset low in the middle of a cycle that would otherwise load. It checks that the outputs clear before the next edge and that the first edge after release loads normally.

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf #(
  parameter int DATA_W = 21,
  parameter int CS_W   = 2,
  parameter int CKE_W  = 2,
  parameter int ODT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic [DATA_W-1:0] cmd_d,
  input  logic [CS_W-1:0]   cs_n_d,
  input  logic [CKE_W-1:0]  cke_d,
  input  logic [ODT_W-1:0]  odt_d,
  output logic [DATA_W-1:0] cmd_q,
  output logic [CS_W-1:0]   cs_n_q,
  output logic [CKE_W-1:0]  cke_q,
  output logic [ODT_W-1:0]  odt_q
);

  logic any_sel;
  logic cmd_load;

  assign any_sel  = ~(&cs_n_d);
  assign cmd_load = ~gate_en | any_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_load) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= '0;
      cke_q  <= '0;
      odt_q  <= '0;
    end else begin
      cs_n_q <= cs_n_d;
      cke_q  <= cke_d;
      odt_q  <= odt_d;
    end
  end

  // R2: both selects idle with gating on -> command bits hold
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (&cs_n_d)) |=> $stable(cmd_q));

  // R3: a selected edge with gating on loads
  a_r3_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !(&cs_n_d)) |=> (cmd_q == $past(cmd_d)));

  // R4: gating off loads on every edge
  a_r4_ungated_load: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (cmd_q == $past(cmd_d)));

  // R5: clock-enable and termination bits always follow their inputs
  a_r5_side_load: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cke_q == $past(cke_d) && odt_q == $past(odt_d)));

  // R6: chip selects always follow their inputs
  a_r6_cs_load: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_n_q == $past(cs_n_d)));

  // R7, R8: outputs are zero whenever reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r7_reset_clear: assert (cmd_q == '0 && cs_n_q == '0 && cke_q == '0 && odt_q == '0);
    end
  end

endmodule

// File: tb/cmd_reg_buf_bench.sv
module cmd_reg_buf_bench;
  localparam int DW = 21;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          gate_en;
  logic [DW-1:0] cmd_d;
  logic [1:0]    cs_n_d, cke_d, odt_d;
  logic [DW-1:0] cmd_q;
  logic [1:0]    cs_n_q, cke_q, odt_q;

  cmd_reg_buf u_cmd_reg_buf (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cmd_d(cmd_d),
    .cs_n_d(cs_n_d), .cke_d(cke_d), .odt_d(odt_d),
    .cmd_q(cmd_q), .cs_n_q(cs_n_q), .cke_q(cke_q), .odt_q(odt_q)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [DW-1:0] m_cmd;
  logic [1:0]    m_cs, m_cke, m_odt;

  function automatic bit expect_load(bit g, logic [1:0] cs);
    return !g || (cs != 2'b11);
  endfunction

  function automatic string cmd_tag(bit g, logic [1:0] cs);
    if (!g) return "R4";
    if (cs == 2'b11) return "R2";
    return "R3";
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, 32'(cmd_q), 32'(m_cmd));
    chk("R6", 32'(cs_n_q), 32'(m_cs));
    chk("R5", 32'(cke_q), 32'(m_cke));
    chk("R5", 32'(odt_q), 32'(m_odt));
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rst_n) begin
      if (expect_load(gate_en, cs_n_d)) m_cmd = cmd_d;
      m_cs = cs_n_d; m_cke = cke_d; m_odt = odt_d;
    end
    @(negedge clk);
  endtask

  task automatic rand_in();
    cmd_d = DW'($urandom); cke_d = 2'($urandom);
    odt_d = 2'($urandom); cs_n_d = 2'($urandom);
  endtask

  task automatic model_clear();
    m_cmd = '0; m_cs = '0; m_cke = '0; m_odt = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; gate_en = 1'b1;
    cmd_d = '1; cs_n_d = 2'b00; cke_d = 2'b11; odt_d = 2'b11;
    model_clear();
    repeat (3) @(negedge clk);
    check_all("R8");
    rst_n = 1'b1;

    // Every chip-select combination, gating on and off (R2, R3, R4)
    for (int g = 0; g < 2; g++) begin
      for (int cs = 0; cs < 4; cs++) begin
        gate_en = 1'b1; cs_n_d = 2'b00; cmd_d = DW'($urandom);
        cycle();
        gate_en = g[0]; cs_n_d = cs[1:0]; rand_in(); cs_n_d = cs[1:0];
        cycle();
        check_all(cmd_tag(g[0], cs[1:0]));
      end
    end

    // Hold coinciding with unconditional reload (R2 with R5, R6)
    gate_en = 1'b1; cs_n_d = 2'b01; cmd_d = 21'h0ABCDE; cycle();
    check_all("R3");
    cs_n_d = 2'b11; cmd_d = 21'h154321; cke_d = 2'b10; odt_d = 2'b01; cycle();
    check_all("R2");
    chk("R2", 32'(cmd_q), 32'h0ABCDE);
    chk("R5", 32'(cke_q), 32'h2);
    cke_d = 2'b01; odt_d = 2'b10; cycle();
    check_all("R2");

    // Reset mid-cycle while a load is pending (R7)
    gate_en = 1'b0; cmd_d = 21'h1FFFFF; cs_n_d = 2'b11; cke_d = 2'b11; odt_d = 2'b11; cycle();
    check_all("R4");
    #5 rst_n = 1'b0; model_clear();
    #1 check_all("R7");
    chk("R7", 32'(cmd_q), 32'h0);
    @(negedge clk);

    // Edges during reset change nothing (R8)
    for (int i = 0; i < 4; i++) begin
      gate_en = 1'($urandom); rand_in(); cycle();
      check_all("R8");
    end

    // First edge after release loads (R9)
    rst_n = 1'b1; gate_en = 1'b1; cs_n_d = 2'b10;
    cmd_d = 21'h12345; cke_d = 2'b01; odt_d = 2'b11;
    cycle();
    check_all("R9");
    chk("R9", 32'(cmd_q), 32'h12345);

    // Random traffic (R1)
    for (int i = 0; i < 300; i++) begin
      gate_en = ($urandom % 4) != 0; rand_in();
      if ($urandom % 3 == 0) cs_n_d = 2'b11;
      cycle();
      check_all("R1");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule